// File: doc/BRIEF.md
# Self-Counting AXI4-Lite Word Register Bank

This block is a 32-bit AXI4-Lite slave that holds a bank of forty word-wide registers. Software writes into the general words and reads any word back. The slave also watches its own traffic. One reserved word counts the write requests it has accepted, and a second counts the read requests it has accepted. A third reserved word acts as a sticky alarm. It turns all-ones when software writes one of the reserved words or uses an index past the end of the bank.

Requests are decoded by word index, taken from address bits [7:2]. Every request finishes its handshakes with an OKAY response, including the ones that are refused. The slave handles one write and one read at a time. Each ready signal stays low from the moment the slave captures a request until that request's response has been taken. Words 0, 1 and 2 are the write counter, the read counter and the alarm word, in that order. Words 3 to 39 are general storage.

Top module: `axil_cnt_regs`

## Requirements
- R1: After reset, every word reads as 0x00000000, no response is pending, and AWREADY, WREADY and ARREADY are all high.
- R2: A write to an index from 3 to 39 stores the full WDATA word there, and a later read of that index returns it.
- R3: Word 0 reads as the number of writes accepted to indices 3 to 39 since reset. Writes to any other index leave it unchanged.
- R4: Word 1 counts accepted reads of indices 0 to 39. A read of word 1 returns the count of the reads accepted before that read.
- R5: A write to index 0, 1 or 2 stores nothing and leaves both counters unchanged. It sets word 2 to 0xFFFFFFFF, which then stays set until reset.
- R6: A read or write whose index is 40 or above sets word 2 to 0xFFFFFFFF. It changes no other word and neither counter, and such a read returns 0x00000000.
- R7: The write address handshake and the write data handshake may complete together or in either order. BVALID rises only after both have completed.
- R8: Once raised, BVALID stays high until BREADY. RVALID stays high, with RDATA unchanged, until RREADY.
- R9: AWREADY and WREADY stay low from the capture of their channel until the write response handshake. ARREADY stays low while a read response is pending.
- R10: Address bits [1:0] do not affect which word a request selects.
- R11: BRESP and RRESP are always 2'b00 (OKAY), including for refused requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 8 | Write byte address; bits [7:2] select the word |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | 8 | Read byte address; bits [7:2] select the word |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |

## Verification
The assertions assume a master that follows AXI4-Lite. A valid signal, once raised, is held until its handshake completes. The master never starts a second request in one direction before the first response has been taken. The stimulus obeys this. Each driver task raises valid only after a falling edge, keeps it up until it has seen the matching ready at a falling edge, and drops it just after the next rising edge. The read and write tasks run one after another, so the read port and the write port never carry two requests at once.

// File: rtl/axil_cnt_pkg.sv
package axil_cnt_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    ACC_GENERAL  = 2'd0,
    ACC_RESERVED = 2'd1,
    ACC_OUTSIDE  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/axil_cnt_wr_path.sv
module axil_cnt_wr_path #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              cmt_en,
  output logic [IDX_W-1:0]  cmt_idx,
  output logic [DATA_W-1:0] cmt_data
);
  logic              aw_got_q, w_got_q, bvalid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  assign awready  = !aw_got_q && !bvalid_q;
  assign wready   = !w_got_q && !bvalid_q;
  assign bvalid   = bvalid_q;
  assign cmt_en   = aw_got_q && w_got_q && !bvalid_q;
  assign cmt_idx  = idx_q;
  assign cmt_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      bvalid_q <= 1'b0;
      idx_q    <= '0;
      data_q   <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_got_q <= 1'b1;
        idx_q    <= awaddr[ADDR_W-1:2];
      end
      if (wvalid && wready) begin
        w_got_q <= 1'b1;
        data_q  <= wdata;
      end
      if (cmt_en) begin
        aw_got_q <= 1'b0;
        w_got_q  <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  // R8: the write response is held until the master takes it
  p_b_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);

  // R9: no new address or data is taken while a response is pending
  p_one_write_r9: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> !awready && !wready);

  // R7: the response rises only after both channels were captured
  p_b_after_both_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bvalid) |-> $past(aw_got_q) && $past(w_got_q));
endmodule

// File: rtl/axil_cnt_rd_path.sv
module axil_cnt_rd_path #(
  parameter int ADDR_W = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx
);
  logic rvalid_q;

  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rd_en   = arvalid && arready;
  assign rd_idx  = araddr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst)                     rvalid_q <= 1'b0;
    else if (rd_en)              rvalid_q <= 1'b1;
    else if (rvalid_q && rready) rvalid_q <= 1'b0;
  end

  // R8: read response held until accepted
  p_r_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid);

  // R9: no read address taken while data is pending
  p_one_read_r9: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> !arready);
endmodule

// File: rtl/axil_cnt_store.sv
module axil_cnt_store
  import axil_cnt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int NUM_WORDS = 40,
  parameter int WCNT_IDX  = 0,
  parameter int RCNT_IDX  = 1,
  parameter int ERR_IDX   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [DATA_W-1:0] wcnt_q, rcnt_q, err_q;
  acc_kind_e         wr_kind, rd_kind;

  function automatic acc_kind_e classify(input logic [IDX_W-1:0] idx);
    if (int'(idx) >= NUM_WORDS) return ACC_OUTSIDE;
    if (int'(idx) == WCNT_IDX || int'(idx) == RCNT_IDX || int'(idx) == ERR_IDX)
      return ACC_RESERVED;
    return ACC_GENERAL;
  endfunction

  always_comb begin
    wr_kind = classify(wr_idx);
    rd_kind = classify(rd_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (wr_en && wr_kind == ACC_GENERAL) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
      err_q  <= '0;
    end else begin
      if (wr_en && wr_kind == ACC_GENERAL) wcnt_q <= wcnt_q + 1'b1;
      if (rd_en && rd_kind != ACC_OUTSIDE) rcnt_q <= rcnt_q + 1'b1;
      if ((wr_en && wr_kind != ACC_GENERAL) || (rd_en && rd_kind == ACC_OUTSIDE))
        err_q <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_kind == ACC_OUTSIDE)         rd_data <= '0;
      else if (int'(rd_idx) == WCNT_IDX)  rd_data <= wcnt_q;
      else if (int'(rd_idx) == RCNT_IDX)  rd_data <= rcnt_q;
      else if (int'(rd_idx) == ERR_IDX)   rd_data <= err_q;
      else                                rd_data <= mem[rd_idx];
    end
  end

  // R3: the write counter moves by at most one per cycle
  p_wcnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    wcnt_q == $past(wcnt_q) || wcnt_q == $past(wcnt_q) + 1'b1);

  // R5: once raised the alarm word stays all-ones
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err_q != '0 |=> err_q == '1);

  // R6: an out-of-range write never moves the write counter
  p_oor_nocount_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_kind == ACC_OUTSIDE |=> $stable(wcnt_q));

  // R8: read data stays put while no new read is taken
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/axil_cnt_regs.sv
module axil_cnt_regs
  import axil_cnt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready
);
  localparam int IDX_W = ADDR_W - 2;

  logic              cmt_en, rd_en;
  logic [IDX_W-1:0]  cmt_idx, rd_idx;
  logic [DATA_W-1:0] cmt_data;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  axil_cnt_wr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .cmt_en(cmt_en), .cmt_idx(cmt_idx), .cmt_data(cmt_data)
  );

  axil_cnt_rd_path #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rvalid(s_rvalid), .rready(s_rready),
    .rd_en(rd_en), .rd_idx(rd_idx)
  );

  axil_cnt_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(cmt_en), .wr_idx(cmt_idx), .wr_data(cmt_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(s_rdata)
  );
endmodule

// File: tb/axil_cnt_regs_test.sv
`timescale 1ns/1ps
module axil_cnt_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
  logic        s_arvalid = 1'b0, s_rready = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] m_mem [40];
  logic [31:0] m_wcnt, m_rcnt, m_err;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  axil_cnt_regs uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each read beat against the queued expectation
  always @(negedge clk) begin
    if (!rst && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected read beat", s_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(s_rdata === e, t, s_rdata, e);
        chk(s_rresp === 2'b00, "R11 rresp", {30'b0, s_rresp}, 32'h0);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 40; i++) m_mem[i] = '0;
    m_wcnt = '0; m_rcnt = '0; m_err = '0;
    @(negedge clk);
  endtask

  // order: 0 both channels together, 1 address first, 2 data first
  task automatic do_write(input logic [7:0] addr, input logic [31:0] data,
                          input int order, input int b_delay);
    int idx;
    idx = int'(addr[7:2]);
    if (idx >= 40 || idx < 3) m_err = '1;
    else begin m_mem[idx] = data; m_wcnt = m_wcnt + 1; end
    @(negedge clk);
    s_awaddr = addr; s_wdata = data;
    if (order == 0) begin
      s_awvalid = 1'b1; s_wvalid = 1'b1;
      while (!(s_awready && s_wready)) @(negedge clk);
      @(posedge clk); #1 s_awvalid = 1'b0; s_wvalid = 1'b0;
    end else begin
      if (order == 1) s_awvalid = 1'b1; else s_wvalid = 1'b1;
      while (!(order == 1 ? s_awready : s_wready)) @(negedge clk);
      @(posedge clk); #1 s_awvalid = 1'b0; s_wvalid = 1'b0;
      repeat (3) begin
        @(negedge clk);
        chk(!s_bvalid, "R7 no response before second channel", {31'b0, s_bvalid}, 32'h0);
        chk(order == 1 ? !s_awready : !s_wready, "R9 captured channel blocked",
            {31'b0, (order == 1 ? s_awready : s_wready)}, 32'h0);
      end
      if (order == 1) s_wvalid = 1'b1; else s_awvalid = 1'b1;
      while (!(order == 1 ? s_wready : s_awready)) @(negedge clk);
      @(posedge clk); #1 s_awvalid = 1'b0; s_wvalid = 1'b0;
    end
    if (b_delay > 0) begin
      @(negedge clk);
      while (!s_bvalid) @(negedge clk);
      repeat (b_delay) begin
        @(negedge clk);
        chk(s_bvalid, "R8 bvalid held", {31'b0, s_bvalid}, 32'h1);
        chk(!s_awready && !s_wready, "R9 write ready low while response pending",
            {30'b0, s_awready, s_wready}, 32'h0);
      end
      @(posedge clk); #1;
    end
    s_bready = 1'b1;
    do @(negedge clk); while (!s_bvalid);
    chk(s_bresp === 2'b00, "R11 bresp", {30'b0, s_bresp}, 32'h0);
    @(posedge clk); #1 s_bready = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] addr, input int r_delay, input string tag);
    int idx;
    logic [31:0] e, held;
    idx = int'(addr[7:2]);
    if (idx >= 40)            begin e = '0; m_err = '1; end
    else if (idx == 0)        e = m_wcnt;
    else if (idx == 1)        e = m_rcnt;
    else if (idx == 2)        e = m_err;
    else                      e = m_mem[idx];
    if (idx < 40) m_rcnt = m_rcnt + 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    s_araddr = addr; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(posedge clk); #1 s_arvalid = 1'b0;
    if (r_delay > 0) begin
      @(negedge clk);
      while (!s_rvalid) @(negedge clk);
      held = s_rdata;
      repeat (r_delay) begin
        @(negedge clk);
        chk(s_rvalid && s_rdata === held, "R8 rvalid and rdata held", s_rdata, held);
        chk(!s_arready, "R9 arready low while data pending", {31'b0, s_arready}, 32'h0);
      end
      @(posedge clk); #1;
    end
    s_rready = 1'b1;
    do @(negedge clk); while (!s_rvalid);
    @(posedge clk); #1 s_rready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle state after reset
    chk(s_awready && s_wready && s_arready, "R1 ready after reset",
        {29'b0, s_awready, s_wready, s_arready}, 32'h7);
    chk(!s_bvalid && !s_rvalid, "R1 nothing pending after reset",
        {30'b0, s_bvalid, s_rvalid}, 32'h0);
    do_read(8'd0,      0, "R1 word0 zero");
    do_read(8'd4,      0, "R1 read counter after one read");
    do_read(8'd8,      0, "R1 alarm clear");
    do_read(8'd20,     0, "R1 general word zero");
    do_read(8'd156,    0, "R1 last word zero");

    // R2/R7: all three channel orders
    do_write(8'd12,  32'hDEADBEEF, 0, 0);
    do_write(8'd40,  32'h12345678, 1, 0);
    do_write(8'd156, 32'hA5A5_0F0F, 2, 3);
    // R10: low address bits ignored on write and read
    do_write(8'd83,  32'hCAFEF00D, 0, 0);
    do_read(8'd12,  0, "R2 word3 readback");
    do_read(8'd42,  0, "R2 R10 word10 readback via offset 2");
    do_read(8'd156, 4, "R2 word39 readback with delay");
    do_read(8'd80,  0, "R10 word20 written with offset 3");
    do_read(8'd0,   0, "R3 write count four");
    do_read(8'd5,   0, "R4 read count before this read");
    do_read(8'd8,   0, "R5 alarm still clear");

    // R5: reserved writes refused and flagged
    do_write(8'd0, 32'h0000_00FF, 0, 0);
    do_write(8'd4, 32'h1111_1111, 1, 0);
    do_read(8'd0, 0, "R5 write counter unchanged by reserved writes");
    do_read(8'd4, 0, "R5 read counter not overwritten");
    do_read(8'd8, 0, "R5 alarm set by reserved write");
    do_write(8'd16, 32'h0BAD_CAFE, 0, 0);
    do_read(8'd8, 0, "R5 alarm stays set");
    do_read(8'd16, 0, "R2 word4 after alarm");

    // R6: out-of-range write
    do_reset();
    do_write(8'd160, 32'hFFFF_0000, 0, 2);
    do_write(8'd252, 32'h0F0F_0F0F, 2, 0);
    do_read(8'd8, 0, "R6 alarm set by out-of-range write");
    do_read(8'd0, 0, "R6 write counter untouched");
    do_read(8'd4, 0, "R6 read counter");

    // R6: out-of-range read
    do_reset();
    do_read(8'd200, 2, "R6 out-of-range read returns zero");
    do_read(8'd4,   0, "R6 out-of-range read not counted");
    do_read(8'd8,   0, "R6 alarm set by out-of-range read");
    do_read(8'd124, 0, "R6 no storage changed");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every read returned", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule